// File: doc/BRIEF.md
# Operand Forwarding and Flush Sequencer

This block is the hazard controller of a three-stage in-order integer pipeline (fetch/decode, execute, write-back) in which the register file is only written in the last stage. Without it, an instruction that reads a register written by one of the two instructions just ahead of it would have to hold the first stage for three clocks until the write lands. Instead, the controller remembers the destination register of the previous two executed instructions and tells the ALU operand muxes to take the execute-stage result or the write-back-stage result in place of the stale register-file value.

The block also owns the program counter and the three stage enables. After reset, and after every taken control transfer, the enables ramp up one stage per clock, so the instruction fetched behind a jump moves through the pipe without executing. The ALU datapath and the register file sit outside the block; it sees only register indices, flags, the PC-write request and the target address.

Top module: `hzd_fwd_ctrl`

## Requirements
- R1: While rst_ni is low, stage_en_o is 000, pc_o is 0 and op_sel_o is 000.
- R2: Out of the all-off state the stage enables step 000, 001, 011, 111 on successive clocks and then stay at 111 until a PC write is taken.
- R3: The PC does not move on the 000 to 001 step; it grows by 4 on the 001 to 011 step, on the 011 to 111 step and on every clock at 111 without a PC write.
- R4: With stage_en_o at 111 and pc_wr_i high, the next clock loads pc_o with pc_tgt_i having bit 0 cleared and returns stage_en_o to 000.
- R5: pc_wr_i has no effect while stage_en_o is not 111: the ramp and the PC step continue as in R2 and R3.
- R6: op_sel_o is 001 (source 1 from execute result) when source 1 is a register and equals the destination of the instruction executed on the previous clock, that instruction having written a register.
- R7: op_sel_o is 010 (source 2 from execute result) for the same match on source 2.
- R8: op_sel_o is 011 (source 1 from write-back result) or 100 (source 2 from write-back result) when the match is with the instruction executed two clocks earlier.
- R9: Only one code is output; the order of precedence is 001, 010, 011, 100, so when both earlier results match a source the execute result wins.
- R10: A source flagged as immediate, or an earlier instruction not flagged as writing a register, never produces a match; op_sel_o is then 000.
- R11: Register index 0 never produces a match, on the source or the destination side.
- R12: op_sel_o is 000 while the execute enable (stage_en_o bit 1) is low, and a clock with execute disabled records no producing instruction, so nothing issued before a flush is forwarded after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src1_idx_i | input | 5 | Source 1 register index of the instruction in execute |
| src2_idx_i | input | 5 | Source 2 register index of the instruction in execute |
| src1_reg_i | input | 1 | Source 1 is read from a register |
| src2_reg_i | input | 1 | Source 2 is read from a register |
| dst_idx_i | input | 5 | Destination index of the instruction in execute |
| dst_we_i | input | 1 | Instruction in execute writes a register |
| pc_wr_i | input | 1 | Taken control transfer request |
| pc_tgt_i | input | 32 | Control transfer target |
| op_sel_o | output | 3 | Operand source code: 000 none, 001/010 from execute, 011/100 from write-back |
| stage_en_o | output | 3 | Stage enables, bit 0 first stage |
| pc_o | output | 32 | Program counter |

## Verification
The forwarding choice is driven with a dependency on the previous instruction, on the one two ahead, on both at once, and on cross pairs where source 1 hits one slot and source 2 the other; these separate the four codes and pin down the precedence order. Masking patterns (immediate operand, non-writing producer, register 0) show that a matching index alone is not enough. The sequencer is driven through the reset ramp with an early PC write that must be ignored, then through a jump with an odd target, with dependent sources held during the refill so that both the idle code and the cleared history after a flush are visible.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned STG_N = 3;
  localparam int unsigned SEL_W = 3;

  typedef logic [STG_N-1:0] stg_en_t;

  localparam stg_en_t EN_OFF  = 3'b000;
  localparam stg_en_t EN_ONE  = 3'b001;
  localparam stg_en_t EN_TWO  = 3'b011;
  localparam stg_en_t EN_FULL = 3'b111;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE  = 3'b000,
    SEL_S1_EX = 3'b001,
    SEL_S2_EX = 3'b010,
    SEL_S1_WB = 3'b011,
    SEL_S2_WB = 3'b100
  } op_sel_e;
endpackage

// File: rtl/hzd_seq.sv
module hzd_seq
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pc_wr_i,
  input  logic [XLEN-1:0] pc_tgt_i,
  output stg_en_t         en_o,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  stg_en_t         en_q, en_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            take;

  assign take = (en_q == EN_FULL) && pc_wr_i;

  always_comb begin
    en_d = en_q;
    pc_d = pc_q;
    unique case (en_q)
      EN_OFF: en_d = EN_ONE;
      EN_ONE: begin en_d = EN_TWO;  pc_d = pc_q + STEP; end
      EN_TWO: begin en_d = EN_FULL; pc_d = pc_q + STEP; end
      default: begin
        if (take) begin
          en_d = EN_OFF;
          pc_d = {pc_tgt_i[XLEN-1:1], 1'b0};
        end else begin
          pc_d = pc_q + STEP;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= EN_OFF;
      pc_q <= '0;
    end else begin
      en_q <= en_d;
      pc_q <= pc_d;
    end
  end

  assign en_o = en_q;
  assign pc_o = pc_q;

  AST_RAMP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == EN_OFF |=> en_q == EN_ONE); // R2
  AST_RAMP_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == EN_ONE |=> en_q == EN_TWO); // R2
  AST_RAMP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == EN_TWO |=> en_q == EN_FULL); // R2
  AST_PC_HOLD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == EN_OFF |=> pc_q == $past(pc_q)); // R3
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != EN_OFF && !(en_q == EN_FULL && pc_wr_i)) |=> pc_q == $past(pc_q) + STEP); // R3
  AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == EN_FULL && pc_wr_i) |=> (en_q == EN_OFF && pc_q[0] == 1'b0
      && pc_q[XLEN-1:1] == $past(pc_tgt_i[XLEN-1:1]))); // R4
  AST_EARLY_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != EN_FULL && pc_wr_i) |=> en_q != EN_OFF); // R5
endmodule

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ex_en_i,
  input  logic [RW-1:0] dst_idx_i,
  input  logic          dst_we_i,
  output logic [RW-1:0] ex_rd_o,
  output logic          ex_we_o,
  output logic [RW-1:0] wb_rd_o,
  output logic          wb_we_o
);
  // slot 0: result now in execute register, slot 1: result now in write-back register
  localparam int unsigned DEPTH = 2;

  logic [RW-1:0] rd_q [DEPTH];
  logic          we_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q[0] <= '0;
      we_q[0] <= 1'b0;
    end else begin
      rd_q[0] <= dst_idx_i;
      we_q[0] <= ex_en_i && dst_we_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[g] <= '0;
        we_q[g] <= 1'b0;
      end else begin
        rd_q[g] <= rd_q[g-1];
        we_q[g] <= we_q[g-1];
      end
    end
  end

  assign ex_rd_o = rd_q[0];
  assign ex_we_o = we_q[0];
  assign wb_rd_o = rd_q[1];
  assign wb_we_o = we_q[1];

  AST_BUBBLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_en_i |=> !ex_we_o); // R12
  AST_AGE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wb_we_o == $past(ex_we_o) && wb_rd_o == $past(ex_rd_o))); // R8
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ex_en_i,
  input  logic [RW-1:0] src1_idx_i,
  input  logic [RW-1:0] src2_idx_i,
  input  logic          src1_reg_i,
  input  logic          src2_reg_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output op_sel_e       sel_o
);
  localparam int unsigned NSRC  = 2;
  localparam int unsigned NSLOT = 2;
  localparam int unsigned NHIT  = NSRC * NSLOT;

  logic [RW-1:0] src_idx [NSRC];
  logic          src_reg [NSRC];
  logic [RW-1:0] slot_rd [NSLOT];
  logic          slot_we [NSLOT];
  // bit order = precedence: slot-major, then source
  logic [NHIT-1:0] hit;

  assign src_idx[0] = src1_idx_i;
  assign src_idx[1] = src2_idx_i;
  assign src_reg[0] = src1_reg_i;
  assign src_reg[1] = src2_reg_i;
  assign slot_rd[0] = ex_rd_i;
  assign slot_rd[1] = wb_rd_i;
  assign slot_we[0] = ex_we_i;
  assign slot_we[1] = wb_we_i;

  for (genvar t = 0; t < NSLOT; t++) begin : g_slot
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign hit[t*NSRC + s] = src_reg[s] && slot_we[t]
                               && (src_idx[s] != '0)
                               && (src_idx[s] == slot_rd[t]);
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (ex_en_i) begin
      for (int i = NHIT - 1; i >= 0; i--) begin
        if (hit[i]) sel_o = op_sel_e'(SEL_W'(i + 1));
      end
    end
  end

  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_en_i |-> sel_o == SEL_NONE); // R12
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o inside {SEL_NONE, SEL_S1_EX, SEL_S2_EX, SEL_S1_WB, SEL_S2_WB}); // R9
  AST_SEL_X0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src1_idx_i == '0 && src2_idx_i == '0) |-> sel_o == SEL_NONE); // R11
  AST_SEL_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src1_reg_i && !src2_reg_i) |-> sel_o == SEL_NONE); // R10
  AST_EX_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_en_i && src1_reg_i && src1_idx_i != '0 && ex_we_i && ex_rd_i == src1_idx_i)
      |-> sel_o == SEL_S1_EX); // R9
endmodule

// File: rtl/hzd_fwd_ctrl.sv
module hzd_fwd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned RW      = 5,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RW-1:0]   src1_idx_i,
  input  logic [RW-1:0]   src2_idx_i,
  input  logic            src1_reg_i,
  input  logic            src2_reg_i,
  input  logic [RW-1:0]   dst_idx_i,
  input  logic            dst_we_i,
  input  logic            pc_wr_i,
  input  logic [XLEN-1:0] pc_tgt_i,
  output logic [2:0]      op_sel_o,
  output logic [2:0]      stage_en_o,
  output logic [XLEN-1:0] pc_o
);
  stg_en_t       en;
  logic          ex_en;
  logic [RW-1:0] ex_rd, wb_rd;
  logic          ex_we, wb_we;
  op_sel_e       sel;

  assign ex_en = en[1];

  hzd_seq #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pc_wr_i  (pc_wr_i),
    .pc_tgt_i (pc_tgt_i),
    .en_o     (en),
    .pc_o     (pc_o)
  );

  hzd_track #(.RW(RW)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ex_en_i   (ex_en),
    .dst_idx_i (dst_idx_i),
    .dst_we_i  (dst_we_i),
    .ex_rd_o   (ex_rd),
    .ex_we_o   (ex_we),
    .wb_rd_o   (wb_rd),
    .wb_we_o   (wb_we)
  );

  hzd_fwd_sel #(.RW(RW)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_en_i    (ex_en),
    .src1_idx_i (src1_idx_i),
    .src2_idx_i (src2_idx_i),
    .src1_reg_i (src1_reg_i),
    .src2_reg_i (src2_reg_i),
    .ex_rd_i    (ex_rd),
    .ex_we_i    (ex_we),
    .wb_rd_i    (wb_rd),
    .wb_we_i    (wb_we),
    .sel_o      (sel)
  );

  assign op_sel_o   = sel;
  assign stage_en_o = en;

  AST_RST_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (stage_en_o == 3'b000 && pc_o == '0 && op_sel_o == 3'b000)); // R1
  AST_EN_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en_o inside {3'b000, 3'b001, 3'b011, 3'b111}); // R2
endmodule

// File: tb/tb_hzd_fwd_ctrl.sv
module tb_hzd_fwd_ctrl;
  localparam int XLEN = 32;
  localparam int RW   = 5;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [RW-1:0]   src1_idx_i = '0, src2_idx_i = '0, dst_idx_i = '0;
  logic            src1_reg_i = 1'b0, src2_reg_i = 1'b0, dst_we_i = 1'b0;
  logic            pc_wr_i = 1'b0;
  logic [XLEN-1:0] pc_tgt_i = '0;
  logic [2:0]      op_sel_o, stage_en_o;
  logic [XLEN-1:0] pc_o;

  always #2 clk = ~clk;

  hzd_fwd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .src1_idx_i(src1_idx_i), .src2_idx_i(src2_idx_i),
    .src1_reg_i(src1_reg_i), .src2_reg_i(src2_reg_i),
    .dst_idx_i(dst_idx_i), .dst_we_i(dst_we_i),
    .pc_wr_i(pc_wr_i), .pc_tgt_i(pc_tgt_i),
    .op_sel_o(op_sel_o), .stage_en_o(stage_en_o), .pc_o(pc_o)
  );

  typedef struct {
    logic [2:0]      sel;
    logic [2:0]      en;
    logic [XLEN-1:0] pc;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // reference state
  logic [2:0]      m_en = 3'b000;
  logic [XLEN-1:0] m_pc = '0;
  logic [RW-1:0]   m_exrd = '0, m_wbrd = '0;
  logic            m_exwe = 0, m_wbwe = 0;

  function automatic logic match(logic r, logic [RW-1:0] s, logic we, logic [RW-1:0] d);
    return r && we && s != 0 && s == d;
  endfunction

  task automatic step(input logic [RW-1:0] s1, input logic [RW-1:0] s2,
                      input logic r1, input logic r2,
                      input logic [RW-1:0] d, input logic we,
                      input logic pw, input logic [XLEN-1:0] tgt, input string tag);
    exp_t e;
    src1_idx_i = s1; src2_idx_i = s2; src1_reg_i = r1; src2_reg_i = r2;
    dst_idx_i = d; dst_we_i = we; pc_wr_i = pw; pc_tgt_i = tgt;
    e.sel = 3'b000;
    if (m_en[1]) begin
      if      (match(r1, s1, m_exwe, m_exrd)) e.sel = 3'b001;
      else if (match(r2, s2, m_exwe, m_exrd)) e.sel = 3'b010;
      else if (match(r1, s1, m_wbwe, m_wbrd)) e.sel = 3'b011;
      else if (match(r2, s2, m_wbwe, m_wbrd)) e.sel = 3'b100;
    end
    e.en = m_en; e.pc = m_pc; e.tag = tag;
    q.push_back(e);
    // advance reference to next edge
    m_wbrd = m_exrd; m_wbwe = m_exwe;
    m_exrd = d;      m_exwe = m_en[1] && we;
    case (m_en)
      3'b000: m_en = 3'b001;
      3'b001: begin m_en = 3'b011; m_pc = m_pc + 4; end
      3'b011: begin m_en = 3'b111; m_pc = m_pc + 4; end
      default: begin
        if (pw) begin m_en = 3'b000; m_pc = {tgt[XLEN-1:1], 1'b0}; end
        else m_pc = m_pc + 4;
      end
    endcase
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (op_sel_o !== e.sel || stage_en_o !== e.en || pc_o !== e.pc) begin
          bad++;
          $display("FAIL %s: sel=%b en=%b pc=%h expected sel=%b en=%b pc=%h",
                   e.tag, op_sel_o, stage_en_o, pc_o, e.sel, e.en, e.pc);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    src1_idx_i = 5'd3; src2_idx_i = 5'd3; src1_reg_i = 1; src2_reg_i = 1;
    repeat (3) @(negedge clk);
    #1;
    total++;
    if (op_sel_o !== 3'b000 || stage_en_o !== 3'b000 || pc_o !== '0) begin
      bad++;
      $display("FAIL R1: sel=%b en=%b pc=%h expected sel=000 en=000 pc=0",
               op_sel_o, stage_en_o, pc_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    // ramp with an early jump request that must be ignored
    step(5'd1, 5'd2, 1, 1, 5'd1, 1, 1, 32'h0000_0800, "R2 R5 ramp off");
    step(5'd1, 5'd2, 1, 1, 5'd1, 1, 1, 32'h0000_0800, "R5 ramp one");
    step(5'd0, 5'd0, 0, 0, 5'd4, 1, 0, 0, "R3 ramp two");
    step(5'd0, 5'd0, 0, 0, 5'd5, 1, 0, 0, "R3 full");
    // execute-result forwarding
    step(5'd5, 5'd9, 1, 1, 5'd6, 1, 0, 0, "R6 src1 from execute");
    step(5'd9, 5'd6, 1, 1, 5'd7, 1, 0, 0, "R7 src2 from execute");
    step(5'd0, 5'd0, 0, 0, 5'd9, 1, 0, 0, "R3 spacer");
    step(5'd7, 5'd0, 1, 0, 5'd10, 1, 0, 0, "R8 src1 from write-back");
    step(5'd0, 5'd0, 0, 0, 5'd11, 1, 0, 0, "R3 spacer");
    step(5'd0, 5'd10, 0, 1, 5'd12, 1, 0, 0, "R8 src2 from write-back");
    // precedence
    step(5'd0, 5'd0, 0, 0, 5'd8, 1, 0, 0, "R9 producer old");
    step(5'd0, 5'd0, 0, 0, 5'd8, 1, 0, 0, "R9 producer young");
    step(5'd8, 5'd8, 1, 1, 5'd13, 1, 0, 0, "R9 execute wins");
    step(5'd0, 5'd0, 0, 0, 5'd14, 1, 0, 0, "R9 set cross");
    step(5'd13, 5'd14, 1, 1, 5'd0, 0, 0, 0, "R9 src2 execute over src1 write-back");
    // masking
    step(5'd0, 5'd0, 0, 0, 5'd15, 1, 0, 0, "R10 producer");
    step(5'd15, 5'd15, 0, 0, 5'd16, 0, 0, 0, "R10 immediate sources");
    step(5'd16, 5'd16, 1, 1, 5'd17, 1, 0, 0, "R10 non-writing producer");
    step(5'd0, 5'd0, 0, 0, 5'd0, 1, 0, 0, "R11 x0 producer");
    step(5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 0, "R11 x0 sources");
    // jump with odd target, dependent sources held through refill
    step(5'd0, 5'd0, 0, 0, 5'd20, 1, 0, 0, "R3 before jump");
    step(5'd20, 5'd0, 1, 0, 5'd21, 1, 1, 32'h0000_0101, "R4 jump");
    step(5'd21, 5'd20, 1, 1, 5'd22, 1, 0, 0, "R4 R12 flushed off");
    step(5'd21, 5'd20, 1, 1, 5'd22, 1, 0, 0, "R12 refill one");
    step(5'd21, 5'd22, 1, 1, 5'd23, 1, 0, 0, "R12 refill two");
    step(5'd23, 5'd0, 1, 0, 5'd0, 0, 0, 0, "R6 after refill");
    step(5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 0, "R3 tail");
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule